// File: doc/BRIEF.md
# Block-Transfer Configuration Register Slave

This block is a two-wire serial slave, for standard-mode rates of up to 100 kbit/s. It holds a small bank of 8-bit configuration registers. Each register drives a parallel output and takes a fixed value at reset. A host reaches the bank only through block transfers, and every transfer starts at register 0.

In a write, the host sends the write address, a command code and a byte count. The slave acknowledges both of the last two and then drops them. After them come data bytes, which fill registers 0, 1, 2 and so on. In a read, the host sends the read address. The slave answers with a count equal to the number of registers, then the registers in ascending order.

SCL and SDA are oversampled on a system clock that runs at least 16 times the bit rate. The slave never drives SDA high: it only pulls the line low.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave acknowledges address byte D2h (write) and D3h (read). It does not acknowledge any other address, and the rest of that transfer has no effect on the registers.
- R2: In a write, the first two bytes after the address (command code, byte count) are each acknowledged. Their contents never change a register.
- R3: Each data byte of a write is acknowledged and is stored in the next register, starting at register 0. Register k appears on `cfgBytes[8k+7:8k]`, and bits arrive MSB first.
- R4: A write that ends with a stop after any complete data byte keeps every byte received so far. Registers that were not reached keep their values.
- R5: Data bytes past the last register are acknowledged and discarded.
- R6: A read returns the count value 06h first, then registers 0 to 5 in order, MSB first.
- R7: When the host does not acknowledge a read byte, the slave stops driving SDA. It then waits for a new start, and the next transfer works normally.
- R8: A stop or a repeated start in the middle of a byte drops that byte, and no register changes. A restarted write begins again at register 0.
- R9: Reset loads register 0 = 00h, registers 1 to 4 = FFh and register 5 = 06h.
- R10: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen at the pin |
| sdaIn | input | 1 | Serial data line as seen at the pin |
| sdaOe | output | 1 | High pulls SDA low (open-drain drive) |
| cfgBytes | output | 48 | Register bank, register k at bits 8k+7:8k |

## Verification
The assertions assume a well-behaved host. SDA moves only while SCL is low, except for start and stop conditions. The host never makes an SDA edge while SCL is high during a slave-driven bit. Every level is held long enough for the synchronizer and edge detector to see it.

The bench host works in quarter-bit steps of 40 system clocks. It changes data only in the low phase of SCL, and it builds the SDA pin from its own drive wired-AND with the slave's pull-down. Aborted bytes are produced the same lawful way: the host stops the clocking after a few bits and then issues a real stop or start condition.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
  // width of register selectors carried between control and datapath
  localparam int IDX_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             sampleBit;  // shift sampled SDA into receive register
    logic             storeEn;    // commit receive register to bank
    logic [IDX_W-1:0] storeIdx;   // bank slot for storeEn
    logic             loadTx;     // load transmit register
    logic [IDX_W-1:0] txSel;      // 0: count, k: register k-1, else all ones
    logic             shiftTx;    // present next transmit bit
  } dpStrobe_t;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaNow,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  // bit 0 carries SCL, bit 1 carries SDA
  logic [SYNC_STAGES-1:0][1:0] pipe;
  logic [1:0] prevLine;
  logic [1:0] lineNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe[0] <= 2'b11;
    else       pipe[0] <= {sdaIn, sclIn};
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe[s] <= 2'b11;
      else       pipe[s] <= pipe[s-1];
    end
  end

  assign lineNow = pipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLine <= 2'b11;
    else       prevLine <= lineNow;
  end

  assign sdaNow   = lineNow[1];
  assign sclRise  = lineNow[0] & ~prevLine[0];
  assign sclFall  = ~lineNow[0] & prevLine[0];
  assign startDet = lineNow[0] & prevLine[0] & prevLine[1] & ~lineNow[1];
  assign stopDet  = lineNow[0] & prevLine[0] & ~prevLine[1] & lineNow[1];
endmodule

// File: rtl/smb_ctrl.sv
module smb_ctrl
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0] ADDR7    = 7'h69,
  parameter int         NUM_REGS = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdaNow,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output dpStrobe_t  stb,
  output logic       sdaOe
);
  localparam logic [3:0] FIRST_DATA = 4'd3;            // addr, cmd, count precede data
  localparam logic [3:0] LAST_DATA  = FIRST_DATA + 4'(NUM_REGS) - 4'd1;
  localparam logic [3:0] LAST_READ  = 4'(NUM_REGS) + 4'd1;

  ctrlState_t state, nState;
  logic [3:0] bitCnt, nBit;
  logic [3:0] byteNo, nByte, incByte;
  logic       isRead, nRead;
  logic       hostNack, nNack;
  logic [IDX_W-1:0] readSel;

  assign incByte = (byteNo == 4'hF) ? byteNo : byteNo + 4'd1;

  always_comb begin
    if (incByte == 4'd1)                          readSel = '0;
    else if (incByte >= 4'd2 && incByte <= LAST_READ) readSel = IDX_W'(incByte - 4'd1);
    else                                          readSel = '1;
  end

  always_comb begin
    stb    = '0;
    nState = state;
    nBit   = bitCnt;
    nByte  = byteNo;
    nRead  = isRead;
    nNack  = hostNack;
    if (stopDet) begin
      nState = ST_IDLE;
    end else if (startDet) begin
      nState = ST_RX;
      nBit   = '0;
      nByte  = '0;
      nNack  = 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (sclRise && bitCnt < 4'd8) begin
            stb.sampleBit = 1'b1;
            nBit = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            nBit = '0;
            if (byteNo == '0) begin
              if (rxByte[7:1] == ADDR7) begin
                nState = ST_RXACK;
                nRead  = rxByte[0];
              end else begin
                nState = ST_IDLE;
              end
            end else begin
              nState = ST_RXACK;
              if (byteNo >= FIRST_DATA && byteNo <= LAST_DATA) begin
                stb.storeEn  = 1'b1;
                stb.storeIdx = IDX_W'(byteNo - FIRST_DATA);
              end
            end
          end
        end
        ST_RXACK: begin
          if (sclFall) begin
            nByte = incByte;
            if (isRead) begin
              nState     = ST_TX;
              stb.loadTx = 1'b1;
              stb.txSel  = readSel;
            end else begin
              nState = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (sclRise) begin
            nBit = bitCnt + 4'd1;
          end else if (sclFall) begin
            if (bitCnt == 4'd8) begin
              nState = ST_TXACK;
              nBit   = '0;
            end else begin
              stb.shiftTx = 1'b1;
            end
          end
        end
        ST_TXACK: begin
          if (sclRise) begin
            nNack = sdaNow;
          end else if (sclFall) begin
            if (hostNack) begin
              nState = ST_IDLE;
            end else begin
              nByte      = incByte;
              nState     = ST_TX;
              stb.loadTx = 1'b1;
              stb.txSel  = readSel;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      byteNo   <= '0;
      isRead   <= 1'b0;
      hostNack <= 1'b0;
    end else begin
      state    <= nState;
      bitCnt   <= nBit;
      byteNo   <= nByte;
      isRead   <= nRead;
      hostNack <= nNack;
    end
  end

  assign sdaOe = (state == ST_RXACK) || (state == ST_TX && !txBit);
endmodule

// File: rtl/smb_regs.sv
module smb_regs
  import smb_cfg_pkg::*;
#(
  parameter int                  NUM_REGS    = 6,
  parameter logic [8*NUM_REGS-1:0] RESET_IMAGE = '0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sdaNow,
  input  dpStrobe_t             stb,
  output logic [7:0]            rxByte,
  output logic                  txBit,
  output logic [8*NUM_REGS-1:0] cfgBytes
);
  logic [NUM_REGS-1:0][7:0] bank;
  logic [7:0] rxShift, txShift, txByte;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                    bank[g] <= RESET_IMAGE[8*g +: 8];
      else if (stb.storeEn && stb.storeIdx == IDX_W'(g)) bank[g] <= rxShift;
    end
  end

  always_comb begin
    txByte = 8'hFF;
    if (stb.txSel == '0) txByte = 8'(NUM_REGS);
    for (int k = 0; k < NUM_REGS; k++)
      if (stb.txSel == IDX_W'(k + 1)) txByte = bank[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= 8'hFF;
    end else begin
      if (stb.sampleBit) rxShift <= {rxShift[6:0], sdaNow};
      if (stb.loadTx)       txShift <= txByte;
      else if (stb.shiftTx) txShift <= {txShift[6:0], 1'b1};
    end
  end

  assign rxByte   = rxShift;
  assign txBit    = txShift[7];
  assign cfgBytes = bank;
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0]            ADDR7       = 7'h69,
  parameter int                    NUM_REGS    = 6,
  parameter logic [8*NUM_REGS-1:0] RESET_IMAGE = 48'h06_FF_FF_FF_FF_00
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  output logic [8*NUM_REGS-1:0] cfgBytes
);
  logic sdaNow, sclRise, sclFall, startDet, stopDet;
  logic [7:0] rxByte;
  logic txBit;
  dpStrobe_t stb;

  smb_line_sync #(.SYNC_STAGES(2)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaNow(sdaNow), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  smb_ctrl #(.ADDR7(ADDR7), .NUM_REGS(NUM_REGS)) u_ctrl (
    .clk(clk), .rstN(rstN), .sdaNow(sdaNow), .sclRise(sclRise),
    .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .rxByte(rxByte), .txBit(txBit), .stb(stb), .sdaOe(sdaOe)
  );

  smb_regs #(.NUM_REGS(NUM_REGS), .RESET_IMAGE(RESET_IMAGE)) u_regs (
    .clk(clk), .rstN(rstN), .sdaNow(sdaNow), .stb(stb),
    .rxByte(rxByte), .txBit(txBit), .cfgBytes(cfgBytes)
  );
endmodule

// File: rtl/smb_cfg_checker.sv
module smb_cfg_checker #(
  parameter int                    NUM_REGS    = 6,
  parameter logic [8*NUM_REGS-1:0] RESET_IMAGE = '0
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sclIn,
  input logic                  sdaOe,
  input logic [8*NUM_REGS-1:0] cfgBytes
);
  // R10: drive changes only in the SCL low phase
  p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> !sclIn);

  // R3: register updates land while SCL is low
  p_store_scl_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cfgBytes != $past(cfgBytes)) |-> !sclIn);

  // R3: every stored byte is acknowledged in the same cycle
  p_store_acked_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cfgBytes != $past(cfgBytes)) |-> sdaOe);

  // R9: reset image appears after a reset cycle
  p_reset_image_r9: assert property (@(posedge clk)
    !rstN |=> (cfgBytes == RESET_IMAGE));

  // R7 / R10: no drive held across reset release
  p_no_drive_reset_r7: assert property (@(posedge clk)
    !rstN |=> !sdaOe);
endmodule

bind smb_cfg_slave smb_cfg_checker #(.NUM_REGS(NUM_REGS), .RESET_IMAGE(RESET_IMAGE)) u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe), .cfgBytes(cfgBytes)
);

// File: tb/smb_cfg_slave_test.sv
`timescale 1ns/1ps
module smb_cfg_slave_test;
  localparam time QT = 200ns;  // quarter bit = 40 system clocks
  localparam logic [47:0] DEFAULTS = 48'h06_FF_FF_FF_FF_00;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclPin = 1'b1;
  logic hostSda = 1'b1;
  logic sdaOe;
  logic [47:0] cfgBytes;
  wire  sdaPin = hostSda & ~sdaOe;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  logic [7:0] model [6];
  logic [7:0] expQ[$];
  string      tagQ[$];
  logic [7:0] obsQ[$];

  always #2.5 clk = ~clk;

  smb_cfg_slave uut (
    .clk(clk), .rstN(rstN), .sclIn(sclPin), .sdaIn(sdaPin),
    .sdaOe(sdaOe), .cfgBytes(cfgBytes)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] modelImage();
    logic [47:0] v;
    for (int k = 0; k < 6; k++) v[8*k +: 8] = model[k];
    return v;
  endfunction

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (obsQ.size() > 0 && expQ.size() > 0) begin
        logic [7:0] o, e;
        string t;
        o = obsQ.pop_front();
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, {56'd0, o}, {56'd0, e});
      end
    end
  end

  task automatic sendBit(input logic b);
    hostSda = b; #QT;
    sclPin = 1'b1; #(2*QT);
    sclPin = 1'b0; #QT;
  endtask

  task automatic recvBit(output logic b);
    hostSda = 1'b1; #QT;
    sclPin = 1'b1; #QT;
    b = sdaPin; #QT;
    sclPin = 1'b0; #QT;
  endtask

  task automatic doStart();
    hostSda = 1'b1; #QT;
    sclPin = 1'b1; #QT;
    hostSda = 1'b0; #QT;
    sclPin = 1'b0; #QT;
  endtask

  task automatic doStop();
    hostSda = 1'b0; #QT;
    sclPin = 1'b1; #QT;
    hostSda = 1'b1; #(2*QT);
  endtask

  task automatic writeByte(input logic [7:0] b, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    recvBit(a);
    acked = ~a;
  endtask

  task automatic readByte(input logic ackIt, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) recvBit(b[i]);
    sendBit(~ackIt);
  endtask

  // header of a block write: address, command code, byte count
  task automatic writeHeader(input logic [7:0] cmd, input logic [7:0] cnt, input string req);
    logic a;
    writeByte(8'hD2, a); check({req, " write address ack"}, {63'd0, a}, 64'd1);
    writeByte(cmd, a);   check("R2 command ack", {63'd0, a}, 64'd1);
    writeByte(cnt, a);   check("R2 count ack", {63'd0, a}, 64'd1);
  endtask

  initial begin
    logic a;
    logic [7:0] rb;
    for (int k = 0; k < 6; k++) model[k] = DEFAULTS[8*k +: 8];
    #23 rstN = 1'b1;
    #1000;

    // R9: reset image
    check("R9 reset image", {16'd0, cfgBytes}, {16'd0, DEFAULTS});
    check("R10 idle drive", {63'd0, sdaOe}, 64'd0);

    // R3: full block write
    doStart();
    writeHeader(8'hA5, 8'h3C, "R1");
    for (int k = 0; k < 6; k++) begin
      writeByte(8'h11 * (k + 1), a);
      check("R3 data ack", {63'd0, a}, 64'd1);
      model[k] = 8'h11 * (k + 1);
    end
    doStop();
    check("R3 sequential store", {16'd0, cfgBytes}, {16'd0, modelImage()});
    check("R3 register 0 low slot", {56'd0, cfgBytes[7:0]}, 64'h11);

    // R2: command and count only
    doStart();
    writeHeader(8'hFF, 8'h00, "R1");
    doStop();
    check("R2 header no effect", {16'd0, cfgBytes}, {16'd0, modelImage()});

    // R4: partial write of two bytes
    doStart();
    writeHeader(8'h00, 8'h02, "R1");
    writeByte(8'h9A, a); model[0] = 8'h9A;
    writeByte(8'hBC, a); model[1] = 8'hBC;
    doStop();
    check("R4 partial write", {16'd0, cfgBytes}, {16'd0, modelImage()});

    // R5: overflow write
    doStart();
    writeHeader(8'h00, 8'h08, "R1");
    for (int k = 0; k < 8; k++) begin
      writeByte(8'(k + 1), a);
      check("R5 overflow ack", {63'd0, a}, 64'd1);
      if (k < 6) model[k] = 8'(k + 1);
    end
    doStop();
    check("R5 overflow discarded", {16'd0, cfgBytes}, {16'd0, modelImage()});

    // R1: foreign address
    doStart();
    writeByte(8'hA0, a);
    check("R1 foreign address nack", {63'd0, a}, 64'd0);
    writeByte(8'h00, a);
    writeByte(8'h00, a);
    writeByte(8'h55, a);
    check("R1 foreign transfer nack", {63'd0, a}, 64'd0);
    doStop();
    check("R1 foreign no effect", {16'd0, cfgBytes}, {16'd0, modelImage()});

    // R6: full block read through scoreboard
    doStart();
    writeByte(8'hD3, a);
    check("R1 read address ack", {63'd0, a}, 64'd1);
    expQ.push_back(8'h06); tagQ.push_back("R6 count byte");
    for (int k = 0; k < 6; k++) begin
      expQ.push_back(model[k]); tagQ.push_back($sformatf("R6 read byte %0d", k));
    end
    for (int k = 0; k < 7; k++) begin
      readByte(k < 6, rb);
      obsQ.push_back(rb);
    end
    doStop();

    // R7: early host nack
    doStart();
    writeByte(8'hD3, a);
    expQ.push_back(8'h06);   tagQ.push_back("R7 count before nack");
    expQ.push_back(model[0]); tagQ.push_back("R7 byte 0 before nack");
    readByte(1'b1, rb); obsQ.push_back(rb);
    readByte(1'b0, rb); obsQ.push_back(rb);
    check("R7 released after nack", {63'd0, sdaOe}, 64'd0);
    recvBit(a);
    check("R7 no drive after nack", {63'd0, a}, 64'd1);
    doStop();
    doStart();
    writeHeader(8'h00, 8'h01, "R7");
    writeByte(8'h5E, a); model[0] = 8'h5E;
    doStop();
    check("R7 write after nack", {16'd0, cfgBytes}, {16'd0, modelImage()});

    // R8: stop in mid-byte
    doStart();
    writeHeader(8'h00, 8'h02, "R1");
    writeByte(8'h77, a); model[0] = 8'h77;
    for (int i = 0; i < 4; i++) sendBit(1'b0);
    doStop();
    check("R8 stop mid-byte", {16'd0, cfgBytes}, {16'd0, modelImage()});

    // R8: repeated start in mid-byte
    doStart();
    writeHeader(8'h00, 8'h02, "R1");
    for (int i = 0; i < 3; i++) sendBit(1'b1);
    doStart();
    writeHeader(8'h00, 8'h01, "R8");
    writeByte(8'hC3, a); model[0] = 8'hC3;
    doStop();
    check("R8 restart mid-byte", {16'd0, cfgBytes}, {16'd0, modelImage()});

    #(4*QT);
    check("R6 scoreboard drained", {32'd0, 32'(expQ.size())}, 64'd0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #800us;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule